// File: doc/BRIEF.md
# Interrupt Acknowledge Priority Gate

This block sits beside the sequencer of a small 8-bit microcontroller core and decides, once per clock, whether one pending interrupt request may be taken. It receives a non-maskable request, a vector of maskable requests, a mask bit for each source and a priority bit for each source. It also receives single-cycle pulses from the enable-interrupt and disable-interrupt instructions. The block holds two flags. The global enable flag gates all maskable requests. The in-service priority flag, while clear, keeps low-priority sources out during a high-priority service.

When a request is taken, the block emits a one-cycle acknowledge together with the index of the chosen source, and it updates both flags in the same clock edge. A restore input reloads both flags together, as the return-from-interrupt path needs. Vector fetch and stacking are left to the surrounding core. All pins are plain control and status signals. There is no data stream, so there is no valid/ready handshake and no back-pressure: an acknowledge is a pulse that the core must take in the cycle it appears.

Top module: `irq_ack_gate`

## Requirements
- R1: After reset the global enable flag `ie_o` is 0, the in-service priority flag `isp_o` is 1, and `ack_o` is 0.
- R2: While `ie_o` is 0, no maskable request is acknowledged, whatever its mask and priority bits are.
- R3: While `ie_o` is 1, source i is eligible only if `irq_req[i]`=1 and `irq_mask[i]`=0 (a mask bit of 1 disables the source). In addition, either `irq_lowpri[i]`=0 (high priority) or `isp_o`=1 must hold. A low-priority source (`irq_lowpri[i]`=1) is refused while `isp_o` is 0.
- R4: Among eligible sources, any high-priority source wins over every low-priority one. Within one level the lowest index wins. `ack_idx_o` carries the winner's index in binary.
- R5: A rising edge of `nmi_req` is acknowledged whatever the state of both flags, and it takes precedence over all maskable requests. Such an acknowledge raises `ack_nmi_o`=1 with `ack_idx_o`=0. Holding `nmi_req` high produces no second acknowledge.
- R6: Every acknowledge clears `ie_o`. Acknowledging a high-priority source also clears `isp_o`. A low-priority source or a non-maskable acknowledge leaves `isp_o` unchanged.
- R7: `ei_pulse` sets `ie_o` and `di_pulse` clears it. When both pulses come in the same cycle, the flag ends up 0. An acknowledge in the same cycle as `ei_pulse` leaves `ie_o` at 0.
- R8: `restore_valid` loads `restore_ie` into `ie_o` and `restore_isp` into `isp_o` in one cycle. This load overrides every other flag update in that cycle. An acknowledge decided in that cycle is still issued, using the flags that held before the load.
- R9: The decision uses the inputs and flags present at a clock edge. `ack_o` is high for exactly the cycle after that edge, and the flags show their new values from that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nmi_req | input | 1 | Non-maskable request, taken on its rising edge |
| irq_req | input | NSRC | Maskable request per source |
| irq_mask | input | NSRC | 1 disables the source |
| irq_lowpri | input | NSRC | 1 marks the source low priority |
| ei_pulse | input | 1 | Enable-interrupt instruction pulse |
| di_pulse | input | 1 | Disable-interrupt instruction pulse |
| restore_valid | input | 1 | Reload both flags this cycle |
| restore_ie | input | 1 | Value loaded into the global enable flag |
| restore_isp | input | 1 | Value loaded into the in-service priority flag |
| ack_o | output | 1 | One-cycle acknowledge pulse |
| ack_nmi_o | output | 1 | Acknowledge belongs to the non-maskable request |
| ack_idx_o | output | IDXW | Index of the acknowledged maskable source |
| ie_o | output | 1 | Global enable flag |
| isp_o | output | 1 | In-service priority flag |

## Verification
The assertions assume that `ei_pulse`, `di_pulse` and `restore_valid` are synchronous, single-cycle controls. They also assume that `irq_mask` and `irq_lowpri` are stable in the cycle a request is sampled. The stimulus changes every input only at the falling clock edge. It sets up flag state through the restore input before each request pattern, and it drops every request after one sampled cycle. The non-maskable line is held high only in tests that probe its edge rule.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_NMI  = 2'd1,
    SRC_HI   = 2'd2,
    SRC_LO   = 2'd3
  } src_kind_e;
endpackage

// File: rtl/irq_eligible.sv
module irq_eligible #(
  parameter int NSRC = 8
) (
  input  logic [NSRC-1:0] req,
  input  logic [NSRC-1:0] mask,
  input  logic [NSRC-1:0] lowpri,
  input  logic            ie,
  input  logic            isp,
  output logic [NSRC-1:0] elig_hi,
  output logic [NSRC-1:0] elig_lo
);
  genvar i;
  generate
    for (i = 0; i < NSRC; i++) begin : g_src
      logic open_src;
      assign open_src   = req[i] & ~mask[i] & ie;
      assign elig_hi[i] = open_src & ~lowpri[i];
      assign elig_lo[i] = open_src & lowpri[i] & isp;
    end
  endgenerate
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/irq_flags.sv
module irq_flags
  import irq_gate_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  src_kind_e grant_kind,
  input  logic      ei_pulse,
  input  logic      di_pulse,
  input  logic      restore_valid,
  input  logic      restore_ie,
  input  logic      restore_isp,
  output logic      ie,
  output logic      isp
);
  logic ie_d, isp_d;

  always_comb begin
    ie_d  = ie;
    isp_d = isp;
    if (ei_pulse) ie_d = 1'b1;
    if (di_pulse) ie_d = 1'b0;
    if (grant_kind != SRC_NONE) ie_d = 1'b0;
    if (grant_kind == SRC_HI) isp_d = 1'b0;
    if (restore_valid) begin
      ie_d  = restore_ie;
      isp_d = restore_isp;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ie  <= 1'b0;
      isp <= 1'b1;
    end else begin
      ie  <= ie_d;
      isp <= isp_d;
    end
  end

  // R6
  ie_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_kind != SRC_NONE && !restore_valid) |=> !ie);

  // R6
  isp_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_kind == SRC_HI && !restore_valid) |=> !isp);

  // R6
  isp_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant_kind == SRC_LO || grant_kind == SRC_NMI) && !restore_valid) |=> isp == $past(isp));

  // R7
  ei_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ei_pulse && !di_pulse && grant_kind == SRC_NONE && !restore_valid) |=> ie);

  // R8
  restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restore_valid |=> (ie == $past(restore_ie) && isp == $past(restore_isp)));
endmodule

// File: rtl/irq_ack_gate.sv
module irq_ack_gate
  import irq_gate_pkg::*;
#(
  parameter int NSRC = 8,
  localparam int IDXW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            nmi_req,
  input  logic [NSRC-1:0] irq_req,
  input  logic [NSRC-1:0] irq_mask,
  input  logic [NSRC-1:0] irq_lowpri,
  input  logic            ei_pulse,
  input  logic            di_pulse,
  input  logic            restore_valid,
  input  logic            restore_ie,
  input  logic            restore_isp,
  output logic            ack_o,
  output logic            ack_nmi_o,
  output logic [IDXW-1:0] ack_idx_o,
  output logic            ie_o,
  output logic            isp_o
);
  localparam int NLVL = 2;

  logic            nmi_q, nmi_edge;
  logic [NSRC-1:0] elig [NLVL];
  logic            lvl_found [NLVL];
  logic [IDXW-1:0] lvl_idx [NLVL];
  src_kind_e       kind_d, kind_q;
  logic [IDXW-1:0] idx_d;

  assign nmi_edge = nmi_req & ~nmi_q;

  irq_eligible #(.NSRC(NSRC)) u_elig (
    .req(irq_req), .mask(irq_mask), .lowpri(irq_lowpri),
    .ie(ie_o), .isp(isp_o),
    .elig_hi(elig[0]), .elig_lo(elig[1])
  );

  genvar l;
  generate
    for (l = 0; l < NLVL; l++) begin : g_lvl
      irq_pick #(.N(NSRC), .IW(IDXW)) u_pick (
        .vec(elig[l]), .found(lvl_found[l]), .idx(lvl_idx[l])
      );
    end
  endgenerate

  always_comb begin
    kind_d = SRC_NONE;
    idx_d  = '0;
    if (nmi_edge) begin
      kind_d = SRC_NMI;
    end else if (lvl_found[0]) begin
      kind_d = SRC_HI;
      idx_d  = lvl_idx[0];
    end else if (lvl_found[1]) begin
      kind_d = SRC_LO;
      idx_d  = lvl_idx[1];
    end
  end

  irq_flags u_flags (
    .clk(clk), .rst_n(rst_n), .grant_kind(kind_d),
    .ei_pulse(ei_pulse), .di_pulse(di_pulse),
    .restore_valid(restore_valid), .restore_ie(restore_ie),
    .restore_isp(restore_isp), .ie(ie_o), .isp(isp_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nmi_q     <= 1'b0;
      kind_q    <= SRC_NONE;
      ack_idx_o <= '0;
    end else begin
      nmi_q     <= nmi_req;
      kind_q    <= kind_d;
      ack_idx_o <= idx_d;
    end
  end

  assign ack_o     = (kind_q != SRC_NONE);
  assign ack_nmi_o = (kind_q == SRC_NMI);

  // R2
  mask_ie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_d == SRC_HI || kind_d == SRC_LO) |-> ie_o);

  // R3
  low_isp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_d == SRC_LO) |-> (isp_o && elig[0] == '0));

  // R4
  hi_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_found[0] && !nmi_edge) |=> (ack_o && !ack_nmi_o && ack_idx_o == $past(lvl_idx[0])));

  // R5
  nmi_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_req && !nmi_q) |=> (ack_nmi_o && ack_idx_o == '0));

  // R5
  nmi_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_req && nmi_q) |=> !ack_nmi_o);
endmodule

// File: tb/sim_irq_ack_gate.sv
module sim_irq_ack_gate;
  localparam int NSRC = 8;
  localparam int NVEC = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic nmi = 1'b0;
  logic [NSRC-1:0] req = '0, mask = '0, low = '0;
  logic ei = 1'b0, di = 1'b0, rv = 1'b0, rie = 1'b0, risp = 1'b0;
  logic ack, ack_nmi, ie, isp;
  logic [2:0] idx;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_ack_gate #(.NSRC(NSRC)) u0 (
    .clk(clk), .rst_n(rst_n), .nmi_req(nmi), .irq_req(req),
    .irq_mask(mask), .irq_lowpri(low), .ei_pulse(ei), .di_pulse(di),
    .restore_valid(rv), .restore_ie(rie), .restore_isp(risp),
    .ack_o(ack), .ack_nmi_o(ack_nmi), .ack_idx_o(idx), .ie_o(ie), .isp_o(isp)
  );

  // {ie, isp, req, mask, lowpri, exp_ack, exp_idx, exp_ie, exp_isp}
  localparam logic [31:0] VEC [NVEC] = '{
    {1'b0, 1'b1, 8'h01, 8'h00, 8'h00, 1'b0, 3'd0, 1'b0, 1'b1},
    {1'b1, 1'b1, 8'h01, 8'h00, 8'h00, 1'b1, 3'd0, 1'b0, 1'b0},
    {1'b1, 1'b1, 8'h06, 8'h00, 8'h00, 1'b1, 3'd1, 1'b0, 1'b0},
    {1'b1, 1'b1, 8'h03, 8'h01, 8'h00, 1'b1, 3'd1, 1'b0, 1'b0},
    {1'b1, 1'b1, 8'h03, 8'h03, 8'h00, 1'b0, 3'd0, 1'b1, 1'b1},
    {1'b1, 1'b0, 8'h10, 8'h00, 8'h10, 1'b0, 3'd0, 1'b1, 1'b0},
    {1'b1, 1'b1, 8'h10, 8'h00, 8'h10, 1'b1, 3'd4, 1'b0, 1'b1},
    {1'b1, 1'b1, 8'h30, 8'h00, 8'h10, 1'b1, 3'd5, 1'b0, 1'b0},
    {1'b1, 1'b0, 8'h30, 8'h00, 8'h10, 1'b1, 3'd5, 1'b0, 1'b0},
    {1'b1, 1'b0, 8'hC0, 8'h00, 8'hC0, 1'b0, 3'd0, 1'b1, 1'b0},
    {1'b1, 1'b1, 8'h80, 8'h00, 8'h00, 1'b1, 3'd7, 1'b0, 1'b0},
    {1'b1, 1'b1, 8'hC0, 8'h00, 8'h40, 1'b1, 3'd7, 1'b0, 1'b0}
  };

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic load_flags(input logic e, input logic p);
    @(negedge clk);
    rv = 1'b1; rie = e; risp = p;
    @(negedge clk);
    rv = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #1000000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ack after reset", int'(ack), 0);
    check("R1 ie after reset", int'(ie), 0);
    check("R1 isp after reset", int'(isp), 1);

    for (int v = 0; v < NVEC; v++) begin
      load_flags(VEC[v][31], VEC[v][30]);
      req = VEC[v][29:22]; mask = VEC[v][21:14]; low = VEC[v][13:6];
      @(negedge clk);
      req = '0; mask = '0; low = '0;
      check($sformatf("R3 R4 vec%0d ack", v), int'(ack), int'(VEC[v][5]));
      check($sformatf("R2 R4 vec%0d nmi flag", v), int'(ack_nmi), 0);
      if (VEC[v][5]) check($sformatf("R4 vec%0d idx", v), int'(idx), int'(VEC[v][4:2]));
      check($sformatf("R6 vec%0d ie", v), int'(ie), int'(VEC[v][1]));
      check($sformatf("R6 vec%0d isp", v), int'(isp), int'(VEC[v][0]));
      @(negedge clk);
      check($sformatf("R9 vec%0d pulse ends", v), int'(ack), 0);
    end

    // R5 non-maskable with global enable off
    load_flags(1'b0, 1'b1);
    nmi = 1'b1;
    @(negedge clk);
    check("R5 nmi ack", int'(ack), 1);
    check("R5 nmi flag", int'(ack_nmi), 1);
    check("R5 nmi idx", int'(idx), 0);
    check("R6 nmi isp kept", int'(isp), 1);
    @(negedge clk);
    check("R5 nmi held no reack", int'(ack), 0);
    nmi = 1'b0;

    // R5 precedence over a maskable request
    load_flags(1'b1, 1'b1);
    nmi = 1'b1; req = 8'h01;
    @(negedge clk);
    check("R5 nmi wins flag", int'(ack_nmi), 1);
    check("R6 nmi clears ie", int'(ie), 0);
    check("R6 nmi isp kept", int'(isp), 1);
    @(negedge clk);
    check("R2 maskable blocked after nmi", int'(ack), 0);
    nmi = 1'b0; req = '0;

    // R7 instruction pulses
    @(negedge clk); ei = 1'b1;
    @(negedge clk); ei = 1'b0;
    check("R7 ei sets ie", int'(ie), 1);
    di = 1'b1;
    @(negedge clk); di = 1'b0;
    check("R7 di clears ie", int'(ie), 0);
    ei = 1'b1;
    @(negedge clk); ei = 1'b0;
    ei = 1'b1; di = 1'b1;
    @(negedge clk); ei = 1'b0; di = 1'b0;
    check("R7 ei and di gives 0", int'(ie), 0);
    load_flags(1'b1, 1'b1);
    ei = 1'b1; req = 8'h01;
    @(negedge clk); ei = 1'b0; req = '0;
    check("R7 ack beats ei ack", int'(ack), 1);
    check("R7 ack beats ei ie", int'(ie), 0);

    // R8 restore in the same cycle as a grant
    load_flags(1'b1, 1'b1);
    rv = 1'b1; rie = 1'b0; risp = 1'b1; req = 8'h02;
    @(negedge clk); rv = 1'b0; req = '0;
    check("R8 ack still issued", int'(ack), 1);
    check("R8 idx", int'(idx), 1);
    check("R8 ie loaded", int'(ie), 0);
    check("R8 isp loaded", int'(isp), 1);

    finish_run();
  end
endmodule